// File: doc/BRIEF.md
# Higher-Order Path Pointer Interpreter

This block follows the payload pointer of one higher-order path in a synchronous optical frame. Once per frame a strobe presents the two pointer bytes (first byte `h1_byte`, second byte `h2_byte`) and a flag that marks the concatenation indication of that frame as wrong. From these the state machine decides whether the pointer is usable and tracks the accepted payload offset. It flags single-step justifications, immediate jumps announced by the new-data field, and offsets taken over after a run of identical values.

The machine has three states: `ST_NORM` (locked, code 0), `ST_AIS` (path alarm indication, code 1) and `ST_LOP` (loss of pointer, code 2). The transitions are: LOP→NORM and AIS→NORM on a jump frame or on three identical valid pointers; NORM→AIS and LOP→AIS on three all-ones frames; NORM→LOP and AIS→LOP on nine invalid frames; and any state→LOP on nine frames in a row with a bad concatenation indication. In NORM, jumps, justifications and three-in-a-row offsets change the offset without leaving the state. The control side reads the state and the alarm levels, and takes a one-cycle pulse for every state change and for every offset event.

Top module: `ptr_interp`

## Requirements
- R1: After reset the state is LOP (code 2), the offset is 0, `lop_alm` is 1 and all event pulses are 0.
- R2: The pointer value is `{h1_byte[1:0], h2_byte}`. Only 0 to 782 is in range. The new-data field is `h1_byte[7:4]`. It is "enabled" when it is within one bit of 1001 and "normal" when it is within one bit of 0110. Any other value makes the frame invalid. An enabled field with an out-of-range value is invalid.
- R3: A run of three consecutive frames that carry the same in-range value with a normal field loads that value as the offset and pulses `nptr_ev`. In LOP or AIS this also enters NORM. In NORM the value must differ from the offset and must not qualify as a justification. A different value restarts the run.
- R4: In NORM, a normal-field frame where at least 3 of the five increment bits (value mask 0x2AA: bits 9,7,5,3,1) are inverted against the offset, and at most 2 of the five decrement bits are, adds one to the offset (782 wraps to 0) and pulses `inc_ev`.
- R5: In NORM, a normal-field frame where at least 3 decrement bits (mask 0x155: bits 8,6,4,2,0) are inverted, and at most 2 increment bits are, subtracts one from the offset (0 wraps to 782) and pulses `dec_ev`.
- R6: A frame with an enabled field and an in-range value loads the offset at once, pulses `ndf_ev`, and enters NORM from any state.
- R7: Three consecutive all-ones frames (both bytes 0xFF) move NORM or LOP to AIS. The offset is held.
- R8: Nine consecutive invalid frames move NORM or AIS to LOP. Any frame that is not invalid restarts the count.
- R9: When nine or more consecutive frames have `cc_bad` set, the state is LOP after that frame. This takes priority over every other outcome of the frame, and no offset event fires.
- R10: Outputs change only one cycle after a strobe. Bytes and `cc_bad` seen without a strobe have no effect. Event pulses last one cycle.
- R11: `st_chg` pulses exactly when the state code changes. `lop_alm` and `ais_alm` follow codes 2 and 1.
- R12: At most one of `ndf_ev`, `inc_ev`, `dec_ev` and `nptr_ev` pulses per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_vld | input | 1 | One-cycle strobe per frame marking the bytes valid |
| h1_byte | input | 8 | First pointer byte |
| h2_byte | input | 8 | Second pointer byte |
| cc_bad | input | 1 | Concatenation indication of this frame is wrong |
| state | output | 2 | 0 NORM, 1 AIS, 2 LOP |
| offset | output | 10 | Accepted payload offset |
| st_chg | output | 1 | Pulse on a state change |
| ndf_ev | output | 1 | Pulse: offset jumped on a new-data frame |
| inc_ev | output | 1 | Pulse: positive justification |
| dec_ev | output | 1 | Pulse: negative justification |
| nptr_ev | output | 1 | Pulse: offset taken after three equal values |
| lop_alm | output | 1 | Loss-of-pointer level |
| ais_alm | output | 1 | Path AIS level |

## Verification
The concatenation-indication counter runs independently of the pointer decode, so its ninth bad frame can arrive in the same frame as a valid jump. The bench sends eight bad-indication frames with an unchanged pointer, then a ninth that also carries an enabled new-data field with a fresh in-range offset. The expected result is LOP with a state-change pulse, no `ndf_ev`, and the old offset. A second case stays in LOP under a sustained bad indication while three equal pointers arrive, and checks that lock is regained only after the indication clears and a fresh run of three completes.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
    localparam int           PW       = 10;
    localparam logic [PW-1:0] PTR_LAST = 10'd782;
    localparam logic [PW-1:0] I_MASK   = 10'h2AA;
    localparam logic [PW-1:0] D_MASK   = 10'h155;
    localparam logic [3:0]   NDF_ON   = 4'b1001;
    localparam logic [3:0]   NDF_OFF  = 4'b0110;
    localparam int           VOTE     = 3;

    typedef enum logic [1:0] {
        ST_NORM = 2'd0,
        ST_AIS  = 2'd1,
        ST_LOP  = 2'd2
    } pstate_e;

    typedef enum logic [2:0] {
        K_ALL1, K_JUMP, K_SAME, K_INC, K_DEC, K_CAND, K_BAD
    } kind_e;

    typedef struct packed {
        logic          all1;
        logic          ndf_on;
        logic          ndf_off;
        logic          in_rng;
        logic [PW-1:0] val;
    } hword_t;
endpackage

// File: rtl/ptr_decode.sv
module ptr_decode
    import ptr_pkg::*;
(
    input  logic [7:0] h1_i,
    input  logic [7:0] h2_i,
    output hword_t     hw_o
);
    logic [3:0] nib;
    logic       unused_ss;

    assign nib       = h1_i[7:4];
    assign unused_ss = ^h1_i[3:2];

    always_comb begin
        hw_o.val     = {h1_i[1:0], h2_i};
        hw_o.all1    = &{h1_i, h2_i};
        hw_o.ndf_on  = ($countones(nib ^ NDF_ON) <= 1);
        hw_o.ndf_off = ($countones(nib ^ NDF_OFF) <= 1);
        hw_o.in_rng  = ({h1_i[1:0], h2_i} <= PTR_LAST);
    end
endmodule

// File: rtl/ptr_runcnt.sv
module ptr_runcnt #(
    parameter int LIM = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic hit_i,
    output logic full_o
);
    localparam int CW = $clog2(LIM + 1);
    localparam logic [CW-1:0] TOP = CW'(LIM);

    logic [CW-1:0] cnt_q, cnt_n;

    always_comb begin
        if (!hit_i)
            cnt_n = '0;
        else if (cnt_q == TOP)
            cnt_n = cnt_q;
        else
            cnt_n = cnt_q + 1'b1;
    end

    assign full_o = hit_i && (cnt_n == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (step_i)
            cnt_q <= cnt_n;
    end

    // R8 R9
    run_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);

    // R8 R9
    run_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !hit_i) |=> (cnt_q == '0));
endmodule

// File: rtl/ptr_fsm.sv
module ptr_fsm
    import ptr_pkg::*;
#(
    parameter int INV_LIM = 9,
    parameter int CC_LIM  = 9,
    parameter int AIS_LIM = 3,
    parameter int EQ_LIM  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frm_i,
    input  logic          cc_bad_i,
    input  hword_t        hw_i,
    output pstate_e       state_o,
    output logic [PW-1:0] offset_o,
    output logic          st_chg_o,
    output logic          jump_o,
    output logic          inc_o,
    output logic          dec_o,
    output logic          nptr_o
);
    localparam int EW = $clog2(EQ_LIM + 1);
    localparam logic [EW-1:0] EQ_TOP = EW'(EQ_LIM);

    pstate_e       st_q, st_n;
    logic [PW-1:0] off_q, off_n, diff;
    logic [EW-1:0] cand_cnt_q, cand_cnt_n, cand_run;
    logic [PW-1:0] cand_val_q, cand_val_n;
    logic [3:0]    ic, dc;
    kind_e         kind;
    logic          ais_full, inv_full, cc_full, eq_full;
    logic          jump_n, inc_n, dec_n, nptr_n;
    logic          st_chg_q, jump_q, inc_q, dec_q, nptr_q;

    // frame classification against the held offset
    always_comb begin
        diff = hw_i.val ^ off_q;
        ic   = 4'($countones(diff & I_MASK));
        dc   = 4'($countones(diff & D_MASK));
        if (hw_i.all1)
            kind = K_ALL1;
        else if (hw_i.ndf_on && hw_i.in_rng)
            kind = K_JUMP;
        else if (hw_i.ndf_off && st_q == ST_NORM && diff == '0)
            kind = K_SAME;
        else if (hw_i.ndf_off && st_q == ST_NORM && ic >= 4'(VOTE) && dc < 4'(VOTE))
            kind = K_INC;
        else if (hw_i.ndf_off && st_q == ST_NORM && dc >= 4'(VOTE) && ic < 4'(VOTE))
            kind = K_DEC;
        else if (hw_i.ndf_off && hw_i.in_rng)
            kind = K_CAND;
        else
            kind = K_BAD;
    end

    ptr_runcnt #(.LIM(AIS_LIM)) u_ais (
        .clk(clk), .rst_n(rst_n), .step_i(frm_i),
        .hit_i(kind == K_ALL1), .full_o(ais_full));

    ptr_runcnt #(.LIM(INV_LIM)) u_inv (
        .clk(clk), .rst_n(rst_n), .step_i(frm_i),
        .hit_i(kind == K_BAD), .full_o(inv_full));

    ptr_runcnt #(.LIM(CC_LIM)) u_cc (
        .clk(clk), .rst_n(rst_n), .step_i(frm_i),
        .hit_i(cc_bad_i), .full_o(cc_full));

    // run of identical candidate values
    always_comb begin
        if (cand_cnt_q != '0 && hw_i.val == cand_val_q)
            cand_run = cand_cnt_q + 1'b1;
        else
            cand_run = EW'(1);
        eq_full = (kind == K_CAND) && (cand_run >= EQ_TOP);
    end

    // next state and offset
    always_comb begin
        st_n       = st_q;
        off_n      = off_q;
        jump_n     = 1'b0;
        inc_n      = 1'b0;
        dec_n      = 1'b0;
        nptr_n     = 1'b0;
        cand_val_n = hw_i.val;
        cand_cnt_n = (kind == K_CAND && !eq_full && !cc_full) ? cand_run : '0;
        if (cc_full) begin
            st_n = ST_LOP;
        end else begin
            unique case (st_q)
                ST_NORM: begin
                    if (ais_full)
                        st_n = ST_AIS;
                    else if (inv_full)
                        st_n = ST_LOP;
                    else if (kind == K_JUMP) begin
                        off_n  = hw_i.val;
                        jump_n = 1'b1;
                    end else if (kind == K_INC) begin
                        off_n = (off_q == PTR_LAST) ? '0 : off_q + 1'b1;
                        inc_n = 1'b1;
                    end else if (kind == K_DEC) begin
                        off_n = (off_q == '0) ? PTR_LAST : off_q - 1'b1;
                        dec_n = 1'b1;
                    end else if (eq_full) begin
                        off_n  = hw_i.val;
                        nptr_n = 1'b1;
                    end
                end
                ST_AIS, ST_LOP: begin
                    if (st_q == ST_AIS && inv_full)
                        st_n = ST_LOP;
                    else if (st_q == ST_LOP && ais_full)
                        st_n = ST_AIS;
                    else if (kind == K_JUMP) begin
                        st_n   = ST_NORM;
                        off_n  = hw_i.val;
                        jump_n = 1'b1;
                    end else if (eq_full) begin
                        st_n   = ST_NORM;
                        off_n  = hw_i.val;
                        nptr_n = 1'b1;
                    end
                end
                default: st_n = ST_LOP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= ST_LOP;
            off_q      <= '0;
            cand_cnt_q <= '0;
            cand_val_q <= '0;
        end else if (frm_i) begin
            st_q       <= st_n;
            off_q      <= off_n;
            cand_cnt_q <= cand_cnt_n;
            cand_val_q <= cand_val_n;
        end
    end

    // event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_chg_q <= 1'b0;
            jump_q   <= 1'b0;
            inc_q    <= 1'b0;
            dec_q    <= 1'b0;
            nptr_q   <= 1'b0;
        end else begin
            st_chg_q <= frm_i && (st_n != st_q);
            jump_q   <= frm_i && jump_n;
            inc_q    <= frm_i && inc_n;
            dec_q    <= frm_i && dec_n;
            nptr_q   <= frm_i && nptr_n;
        end
    end

    assign state_o  = st_q;
    assign offset_o = off_q;
    assign st_chg_o = st_chg_q;
    assign jump_o   = jump_q;
    assign inc_o    = inc_q;
    assign dec_o    = dec_q;
    assign nptr_o   = nptr_q;

    // R12
    one_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({jump_q, inc_q, dec_q, nptr_q}));

    // R10
    evt_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_chg_q || jump_q || inc_q || dec_q || nptr_q) |-> $past(frm_i));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frm_i) |-> ($stable(off_q) && $stable(st_q)));

    // R4
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc_q |-> (off_q == (($past(off_q) == PTR_LAST) ? 10'd0 : $past(off_q) + 10'd1)));

    // R5
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_q |-> (off_q == (($past(off_q) == 10'd0) ? PTR_LAST : $past(off_q) - 10'd1)));

    // R11
    chg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_chg_q |-> (st_q != $past(st_q)));

    // R9
    cc_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_i && cc_full) |=> (st_q == ST_LOP && !jump_q && !inc_q && !dec_q && !nptr_q));
endmodule

// File: rtl/ptr_interp.sv
module ptr_interp
    import ptr_pkg::*;
#(
    parameter int INV_LIM = 9,
    parameter int CC_LIM  = 9,
    parameter int AIS_LIM = 3,
    parameter int EQ_LIM  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frm_vld,
    input  logic [7:0] h1_byte,
    input  logic [7:0] h2_byte,
    input  logic       cc_bad,
    output logic [1:0] state,
    output logic [9:0] offset,
    output logic       st_chg,
    output logic       ndf_ev,
    output logic       inc_ev,
    output logic       dec_ev,
    output logic       nptr_ev,
    output logic       lop_alm,
    output logic       ais_alm
);
    hword_t  hw;
    pstate_e st;

    ptr_decode u_dec (
        .h1_i (h1_byte),
        .h2_i (h2_byte),
        .hw_o (hw)
    );

    ptr_fsm #(
        .INV_LIM (INV_LIM),
        .CC_LIM  (CC_LIM),
        .AIS_LIM (AIS_LIM),
        .EQ_LIM  (EQ_LIM)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_i    (frm_vld),
        .cc_bad_i (cc_bad),
        .hw_i     (hw),
        .state_o  (st),
        .offset_o (offset),
        .st_chg_o (st_chg),
        .jump_o   (ndf_ev),
        .inc_o    (inc_ev),
        .dec_o    (dec_ev),
        .nptr_o   (nptr_ev)
    );

    assign state   = st;
    assign lop_alm = (st == ST_LOP);
    assign ais_alm = (st == ST_AIS);
endmodule

// File: tb/ptr_interp_test.sv
`timescale 1ns/1ps
module ptr_interp_test;
    logic       clk = 1'b0, rst_n = 1'b0, frm_vld = 1'b0, cc_bad = 1'b0;
    logic [7:0] h1 = 8'h00, h2 = 8'h00;
    logic [1:0] state;
    logic [9:0] offset;
    logic       st_chg, ndf_ev, inc_ev, dec_ev, nptr_ev, lop_alm, ais_alm;

    localparam logic [1:0] SN = 2'd0, SA = 2'd1, SL = 2'd2;
    localparam logic [4:0] E0 = 5'd0, CHG = 5'd16, NDF = 5'd8, INC = 5'd4, DEC = 5'd2, NPT = 5'd1;
    localparam logic [3:0] NN = 4'b0110, NE = 4'b1001, NX = 4'b0000;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;
    logic [16:0] exp_q[$];
    string       tag_q[$];

    ptr_interp uut (
        .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .h1_byte(h1), .h2_byte(h2),
        .cc_bad(cc_bad), .state(state), .offset(offset), .st_chg(st_chg),
        .ndf_ev(ndf_ev), .inc_ev(inc_ev), .dec_ev(dec_ev), .nptr_ev(nptr_ev),
        .lop_alm(lop_alm), .ais_alm(ais_alm));

    always #2 clk = ~clk;

    task automatic check(input string r, input logic [18:0] act, input logic [18:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    function automatic logic [18:0] pack(input logic [1:0] s, input logic [9:0] o, input logic [4:0] e);
        return {s, o, e, s == SL, s == SA};
    endfunction

    task automatic send(input logic [7:0] a, input logic [7:0] b, input logic c,
                        input logic [1:0] es, input logic [9:0] eo, input logic [4:0] ee,
                        input string r);
        @(posedge clk); #1;
        h1 = a; h2 = b; cc_bad = c; frm_vld = 1'b1;
        exp_q.push_back({es, eo, ee});
        tag_q.push_back(r);
        @(posedge clk); #1;
        frm_vld = 1'b0; h1 = 8'hFF; h2 = 8'hFF; cc_bad = 1'b1;
    endtask

    task automatic fr(input logic [3:0] nib, input logic [9:0] v, input logic c,
                      input logic [1:0] es, input logic [9:0] eo, input logic [4:0] ee,
                      input string r);
        send({nib, 2'b00, v[9:8]}, v[7:0], c, es, eo, ee, r);
    endtask

    // monitor: pops the expectation of each captured frame
    initial begin
        forever begin
            @(posedge clk);
            if (frm_vld) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    check("queue", 19'd1, 19'd0);
                end else begin
                    logic [16:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, {state, offset, st_chg, ndf_ev, inc_ev, dec_ev, nptr_ev, lop_alm, ais_alm},
                          pack(e[16:15], e[14:5], e[4:0]));
                end
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", {state, offset, st_chg, ndf_ev, inc_ev, dec_ev, nptr_ev, lop_alm, ais_alm},
              pack(SL, 10'd0, E0));

        // R3 lock from LOP on three equal pointers
        fr(NN, 10'd100, 1'b0, SL, 10'd0, E0, "R3 lop run1");
        fr(NN, 10'd100, 1'b0, SL, 10'd0, E0, "R3 lop run2");
        fr(NN, 10'd100, 1'b0, SN, 10'd100, CHG | NPT, "R3 lop lock");
        fr(NN, 10'd100, 1'b0, SN, 10'd100, E0, "R2 same pointer");
        // R4 / R5 justifications
        fr(NN, 10'd100 ^ 10'h2AA, 1'b0, SN, 10'd101, INC, "R4 increment");
        fr(NN, 10'd101 ^ 10'h155, 1'b0, SN, 10'd100, DEC, "R5 decrement");
        fr(NE, 10'd782, 1'b0, SN, 10'd782, NDF, "R6 jump in norm");
        fr(NN, 10'd782 ^ 10'h2AA, 1'b0, SN, 10'd0, INC, "R4 wrap to 0");
        fr(NN, 10'd0 ^ 10'h155, 1'b0, SN, 10'd782, DEC, "R5 wrap to 782");
        // R3 restart on a different value
        fr(NN, 10'd14, 1'b0, SN, 10'd782, E0, "R3 cand a1");
        fr(NN, 10'd14, 1'b0, SN, 10'd782, E0, "R3 cand a2");
        fr(NN, 10'd770, 1'b0, SN, 10'd782, E0, "R3 cand b1");
        fr(NN, 10'd770, 1'b0, SN, 10'd782, E0, "R3 cand b2");
        fr(NN, 10'd770, 1'b0, SN, 10'd770, NPT, "R3 cand accept");
        // R8 invalid count, restart, then loss
        for (int k = 0; k < 8; k++) fr(NX, 10'd770, 1'b0, SN, 10'd770, E0, "R8 inv below");
        fr(NN, 10'd770, 1'b0, SN, 10'd770, E0, "R8 restart");
        for (int k = 0; k < 8; k++) fr(NX, 10'd770, 1'b0, SN, 10'd770, E0, "R8 inv again");
        fr(NX, 10'd770, 1'b0, SL, 10'd770, CHG, "R8 ninth to LOP");
        // R7 from LOP, then R6 jump out of AIS
        send(8'hFF, 8'hFF, 1'b0, SL, 10'd770, E0, "R7 ones1");
        send(8'hFF, 8'hFF, 1'b0, SL, 10'd770, E0, "R7 ones2");
        send(8'hFF, 8'hFF, 1'b0, SA, 10'd770, CHG, "R7 LOP to AIS");
        fr(NE, 10'd50, 1'b0, SN, 10'd50, CHG | NDF, "R6 AIS to NORM");
        // R7 from NORM with a restart
        send(8'hFF, 8'hFF, 1'b0, SN, 10'd50, E0, "R7 n ones1");
        send(8'hFF, 8'hFF, 1'b0, SN, 10'd50, E0, "R7 n ones2");
        fr(NN, 10'd50, 1'b0, SN, 10'd50, E0, "R7 restart");
        send(8'hFF, 8'hFF, 1'b0, SN, 10'd50, E0, "R7 n ones1b");
        send(8'hFF, 8'hFF, 1'b0, SN, 10'd50, E0, "R7 n ones2b");
        send(8'hFF, 8'hFF, 1'b0, SA, 10'd50, CHG, "R7 NORM to AIS");
        fr(NN, 10'd60, 1'b0, SA, 10'd50, E0, "R3 ais run1");
        fr(NN, 10'd60, 1'b0, SA, 10'd50, E0, "R3 ais run2");
        fr(NN, 10'd60, 1'b0, SN, 10'd60, CHG | NPT, "R3 AIS to NORM");
        // R9 same-frame conflict: ninth bad indication with a jump
        for (int k = 0; k < 8; k++) fr(NN, 10'd60, 1'b1, SN, 10'd60, E0, "R9 cc below");
        fr(NE, 10'd200, 1'b1, SL, 10'd60, CHG, "R9 cc beats jump");
        fr(NN, 10'd70, 1'b1, SL, 10'd60, E0, "R9 hold1");
        fr(NN, 10'd70, 1'b1, SL, 10'd60, E0, "R9 hold2");
        fr(NN, 10'd70, 1'b1, SL, 10'd60, E0, "R9 hold3");
        fr(NN, 10'd70, 1'b0, SL, 10'd60, E0, "R9 clear run1");
        fr(NN, 10'd70, 1'b0, SL, 10'd60, E0, "R9 clear run2");
        fr(NN, 10'd70, 1'b0, SN, 10'd70, CHG | NPT, "R9 relock");
        // R2 near matches and out-of-range jump
        fr(4'b1101, 10'd400, 1'b0, SN, 10'd400, NDF, "R2 near enabled");
        fr(4'b0111, 10'd400, 1'b0, SN, 10'd400, E0, "R2 near normal");
        fr(NE, 10'd800, 1'b0, SN, 10'd400, E0, "R2 jump out of range");
        // R8 from AIS
        send(8'hFF, 8'hFF, 1'b0, SN, 10'd400, E0, "R8 a ones1");
        send(8'hFF, 8'hFF, 1'b0, SN, 10'd400, E0, "R8 a ones2");
        send(8'hFF, 8'hFF, 1'b0, SA, 10'd400, CHG, "R8 a to AIS");
        for (int k = 0; k < 8; k++) fr(NX, 10'd400, 1'b0, SA, 10'd400, E0, "R8 ais inv");
        fr(NX, 10'd400, 1'b0, SL, 10'd400, CHG, "R8 AIS to LOP");

        // R10 bytes without strobe are ignored
        @(posedge clk); #1;
        h1 = 8'h90; h2 = 8'h05; cc_bad = 1'b1;
        repeat (12) @(posedge clk);
        @(negedge clk);
        check("R10 idle ignored", {state, offset, st_chg, ndf_ev, inc_ev, dec_ev, nptr_ev, lop_alm, ais_alm},
              pack(SL, 10'd400, E0));

        repeat (4) @(posedge clk);
        check("scoreboard drained", 19'(exp_q.size()), 19'd0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule